// File: doc/BRIEF.md
# Alarm Clock Mode Controller

This block sequences the user interface of a 24-hour clock with an alarm. It watches three debounced, clock-synchronous push buttons (adjust, time-confirm and alarm). From them it decides what the four-digit display shows and when the digits typed into the entry buffer get committed. It drives two single-cycle load strobes, one for the running-time counter and one for the alarm register, plus two display-select flags. The downstream display mux gives the entry buffer first priority, then the stored alarm, then the running time.

The alarm button has two jobs. While an entry is in progress it commits the entry into the alarm register. When no entry is in progress it shows the stored alarm time for as long as it is held, up to a timeout of `VIEW_SECONDS` seconds of `TICKS_PER_SEC` clock ticks. Every button acts on its press (a low-to-high change of its level), never on its held level. A button that is already held when clear is released does not count as pressed until it is released and pressed again.

States: `ST_IDLE` (running time shown), `ST_ENTRY` (entry buffer shown), `ST_LOAD_CLK` (time strobe), `ST_LOAD_ALM` (alarm strobe), `ST_PEEK` (stored alarm shown). Transitions:
- idle→entry on an adjust press.
- idle→peek on an alarm press with no adjust press.
- entry→load_clk on a time press.
- entry→load_alm on an alarm press with no time press.
- load_clk→idle and load_alm→idle always.
- peek→entry on an adjust press.
- peek→idle when the alarm button is low or the timeout expires.
- Any state goes to idle on clear.

Top module: `alarm_mode_ctrl`

## Requirements
- R1: While `clr` is high, and in the first cycle after it, all four outputs are low; clear aborts an entry or a view at once.
- R2: A button held high across the release of `clr` has no effect until it goes low and high again.
- R3: An adjust press in idle or peek makes `show_entry` high from the next cycle; further adjust presses keep it high.
- R4: A time press during entry gives `load_clock` high for exactly one cycle, then idle; a time press outside entry has no effect.
- R5: An alarm press during entry gives `load_alarm` high for exactly one cycle, then idle, even if the alarm button is still held.
- R6: An alarm press in idle makes `show_alarm` high from the next cycle until the cycle after the button goes low.
- R7: With the alarm button held, `show_alarm` stays high for exactly TICKS_PER_SEC*VIEW_SECONDS cycles and then drops without a new press.
- R8: When time and alarm are pressed in the same cycle during entry, only `load_clock` pulses.
- R9: When adjust and alarm are pressed in the same cycle in idle, entry wins. An adjust press during peek also switches to entry.
- R10: At most one of the four outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear, active high |
| adj_btn | input | 1 | Adjust button level (debounced, synchronous) |
| time_btn | input | 1 | Time-confirm button level |
| alarm_btn | input | 1 | Alarm button level |
| load_clock | output | 1 | One-cycle strobe: copy entry buffer into time counter |
| load_alarm | output | 1 | One-cycle strobe: copy entry buffer into alarm register |
| show_entry | output | 1 | Display the entry buffer |
| show_alarm | output | 1 | Display the stored alarm time |

## Verification
Two functions can fall in the same cycle. The alarm press can commit an entry or open the alarm view, and the time and alarm commits can collide. The bench presses time and alarm together during entry, and expects a single clock strobe with no alarm strobe. It also presses adjust and alarm together in idle and expects entry mode with no alarm view. In a third case the alarm button stays held after its commit strobe, and the bench expects idle rather than a view.

// File: rtl/amc_pkg.sv
package amc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ENTRY    = 3'd1,
        ST_LOAD_CLK = 3'd2,
        ST_LOAD_ALM = 3'd3,
        ST_PEEK     = 3'd4
    } amc_state_e;

    localparam int unsigned BTN_COUNT = 3;
    localparam int unsigned BTN_ADJ   = 0;
    localparam int unsigned BTN_TIME  = 1;
    localparam int unsigned BTN_ALARM = 2;

endpackage

// File: rtl/amc_press_detect.sv
module amc_press_detect #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] press
);
    // Previous level resets high so a button held through clear is not a press.
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_btn
            always_ff @(posedge clk or posedge clr) begin
                if (clr) begin
                    prev_q[i] <= 1'b1;
                end else begin
                    prev_q[i] <= level[i];
                end
            end
            assign press[i] = level[i] & ~prev_q[i];
        end
    endgenerate

endmodule

// File: rtl/amc_view_timer.sv
module amc_view_timer #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW   = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam int unsigned LAST = CYCLES - 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST[CW-1:0]) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST[CW-1:0]);

endmodule

// File: rtl/amc_mode_fsm.sv
module amc_mode_fsm
    import amc_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic adj_press,
    input  logic time_press,
    input  logic alarm_press,
    input  logic alarm_level,
    input  logic view_expired,
    output logic viewing,
    output logic load_clock,
    output logic load_alarm,
    output logic show_entry,
    output logic show_alarm
);
    amc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (adj_press)        state_d = ST_ENTRY;
                else if (alarm_press) state_d = ST_PEEK;
            end
            ST_ENTRY: begin
                if (time_press)       state_d = ST_LOAD_CLK;
                else if (alarm_press) state_d = ST_LOAD_ALM;
            end
            ST_LOAD_CLK: state_d = ST_IDLE;
            ST_LOAD_ALM: state_d = ST_IDLE;
            ST_PEEK: begin
                if (adj_press)                         state_d = ST_ENTRY;
                else if (!alarm_level || view_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_clock = 1'b0;
        load_alarm = 1'b0;
        show_entry = 1'b0;
        show_alarm = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_ENTRY:    show_entry = 1'b1;
            ST_LOAD_CLK: load_clock = 1'b1;
            ST_LOAD_ALM: load_alarm = 1'b1;
            ST_PEEK:     show_alarm = 1'b1;
            default:     ;
        endcase
    end

    assign viewing = (state_q == ST_PEEK);

endmodule

// File: rtl/alarm_mode_ctrl.sv
module alarm_mode_ctrl
    import amc_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter int unsigned VIEW_SECONDS  = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic adj_btn,
    input  logic time_btn,
    input  logic alarm_btn,
    output logic load_clock,
    output logic load_alarm,
    output logic show_entry,
    output logic show_alarm
);
    localparam int unsigned VIEW_CYCLES = TICKS_PER_SEC * VIEW_SECONDS;

    logic [BTN_COUNT-1:0] btn_level;
    logic [BTN_COUNT-1:0] btn_press;
    logic                 viewing;
    logic                 view_expired;

    always_comb begin
        btn_level            = '0;
        btn_level[BTN_ADJ]   = adj_btn;
        btn_level[BTN_TIME]  = time_btn;
        btn_level[BTN_ALARM] = alarm_btn;
    end

    amc_press_detect #(.WIDTH(BTN_COUNT)) u_press (
        .clk   (clk),
        .clr   (clr),
        .level (btn_level),
        .press (btn_press)
    );

    amc_view_timer #(.CYCLES(VIEW_CYCLES)) u_timer (
        .clk     (clk),
        .clr     (clr),
        .run     (viewing),
        .expired (view_expired)
    );

    amc_mode_fsm u_fsm (
        .clk          (clk),
        .clr          (clr),
        .adj_press    (btn_press[BTN_ADJ]),
        .time_press   (btn_press[BTN_TIME]),
        .alarm_press  (btn_press[BTN_ALARM]),
        .alarm_level  (alarm_btn),
        .view_expired (view_expired),
        .viewing      (viewing),
        .load_clock   (load_clock),
        .load_alarm   (load_alarm),
        .show_entry   (show_entry),
        .show_alarm   (show_alarm)
    );

endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
    parameter int unsigned VIEW_CYCLES = 8
) (
    input logic clk,
    input logic clr,
    input logic adj_btn,
    input logic time_btn,
    input logic alarm_btn,
    input logic load_clock,
    input logic load_alarm,
    input logic show_entry,
    input logic show_alarm
);
    localparam int unsigned CW = $clog2(VIEW_CYCLES + 2);

    // Consecutive cycles with show_alarm high.
    logic [CW-1:0] peek_run;
    always_ff @(posedge clk or posedge clr) begin
        if (clr)             peek_run <= '0;
        else if (show_alarm) peek_run <= peek_run + 1'b1;
        else                 peek_run <= '0;
    end

    a_r1_quiet_in_clear: assert property (@(posedge clk)
        clr |-> !(load_clock || load_alarm || show_entry || show_alarm));

    a_r3_entry_needs_adjust: assert property (@(posedge clk) disable iff (clr)
        $rose(show_entry) |-> $past(adj_btn));

    a_r4_clock_pulse_once: assert property (@(posedge clk) disable iff (clr)
        load_clock |=> !load_clock && !show_entry && !show_alarm);

    a_r4_clock_from_entry: assert property (@(posedge clk) disable iff (clr)
        load_clock |-> $past(show_entry) && $past(time_btn));

    a_r5_alarm_pulse_once: assert property (@(posedge clk) disable iff (clr)
        load_alarm |=> !load_alarm && !show_alarm && !show_entry);

    a_r5_alarm_from_entry: assert property (@(posedge clk) disable iff (clr)
        load_alarm |-> $past(show_entry) && $past(alarm_btn) && !$past(time_btn));

    a_r6_view_needs_button: assert property (@(posedge clk) disable iff (clr)
        show_alarm |-> $past(alarm_btn));

    a_r7_view_bounded: assert property (@(posedge clk) disable iff (clr)
        show_alarm |-> (peek_run < VIEW_CYCLES[CW-1:0]));

    a_r10_one_output: assert property (@(posedge clk) disable iff (clr)
        $onehot0({load_clock, load_alarm, show_entry, show_alarm}));

endmodule

bind alarm_mode_ctrl amc_checker #(.VIEW_CYCLES(TICKS_PER_SEC * VIEW_SECONDS)) u_amc_checker (
    .clk        (clk),
    .clr        (clr),
    .adj_btn    (adj_btn),
    .time_btn   (time_btn),
    .alarm_btn  (alarm_btn),
    .load_clock (load_clock),
    .load_alarm (load_alarm),
    .show_entry (show_entry),
    .show_alarm (show_alarm)
);

// File: tb/tb_alarm_mode_ctrl.sv
module tb_alarm_mode_ctrl;
    localparam int unsigned TPS  = 4;
    localparam int unsigned SECS = 3;
    localparam int unsigned NV   = TPS * SECS;

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic adj_btn = 1'b0, time_btn = 1'b0, alarm_btn = 1'b0;
    logic load_clock, load_alarm, show_entry, show_alarm;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [3:0] q_exp[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    alarm_mode_ctrl #(.TICKS_PER_SEC(TPS), .VIEW_SECONDS(SECS)) dut (
        .clk(clk), .clr(clr), .adj_btn(adj_btn), .time_btn(time_btn),
        .alarm_btn(alarm_btn), .load_clock(load_clock), .load_alarm(load_alarm),
        .show_entry(show_entry), .show_alarm(show_alarm)
    );

    function automatic logic [3:0] outs();
        return {load_clock, load_alarm, show_entry, show_alarm};
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Driver: set button levels before an edge, queue the outputs due after it.
    // Expected code: {load_clock, load_alarm, show_entry, show_alarm}.
    task automatic step(input logic a, input logic t, input logic l,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        adj_btn = a; time_btn = t; alarm_btn = l;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic direct_check(input logic [3:0] exp, input string tag);
        n_run++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, outs(), exp);
        end
    endtask

    // Monitor: compare a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q_exp.size() > 0) begin
                logic [3:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_run++;
                if (outs() !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %b expected %b", t, outs(), e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                report();
            end
        end
    end

    initial begin
        // R1 / R2: clear with the alarm button held
        alarm_btn = 1'b1;
        repeat (3) @(negedge clk);
        direct_check(4'b0000, "R1 during clear");
        clr = 1'b0;
        step(0, 0, 1, 4'b0000, "R1 first cycle after clear");
        step(0, 0, 1, 4'b0000, "R2 held alarm is no press");
        step(0, 0, 0, 4'b0000, "R2 release");

        // R3 / R4: entry then time commit
        step(1, 0, 0, 4'b0010, "R3 adjust enters entry");
        step(0, 0, 0, 4'b0010, "R3 entry holds");
        step(1, 0, 0, 4'b0010, "R3 second adjust keeps entry");
        step(0, 0, 0, 4'b0010, "R3 entry holds");
        step(0, 1, 0, 4'b1000, "R4 time strobe");
        step(0, 1, 0, 4'b0000, "R4 strobe one cycle");
        step(0, 0, 0, 4'b0000, "R4 idle");
        step(0, 1, 0, 4'b0000, "R4 time in idle ignored");
        step(0, 0, 0, 4'b0000, "R4 idle");

        // R5: alarm commit, button still held
        step(1, 0, 0, 4'b0010, "R5 enter");
        step(0, 0, 0, 4'b0010, "R5 entry");
        step(0, 0, 1, 4'b0100, "R5 alarm strobe");
        step(0, 0, 1, 4'b0000, "R5 held alarm no view");
        step(0, 0, 0, 4'b0000, "R5 idle");

        // R6: view while held, end on release
        step(0, 0, 1, 4'b0001, "R6 view");
        step(0, 0, 1, 4'b0001, "R6 view held");
        step(0, 0, 0, 4'b0000, "R6 release ends view");

        // R7: timeout
        step(0, 0, 1, 4'b0001, "R7 view start");
        for (int i = 1; i < NV; i++) step(0, 0, 1, 4'b0001, "R7 view within window");
        step(0, 0, 1, 4'b0000, "R7 timeout drops view");
        step(0, 0, 1, 4'b0000, "R7 held no restart");
        step(0, 0, 0, 4'b0000, "R7 release");
        step(0, 0, 1, 4'b0001, "R7 new press views again");
        step(0, 0, 0, 4'b0000, "R7 release");

        // R8: time and alarm in the same cycle during entry
        step(1, 0, 0, 4'b0010, "R8 enter");
        step(0, 0, 0, 4'b0010, "R8 entry");
        step(0, 1, 1, 4'b1000, "R8 only clock strobe");
        step(0, 0, 0, 4'b0000, "R8 idle");

        // R9: adjust wins over alarm
        step(1, 0, 1, 4'b0010, "R9 simultaneous adjust and alarm");
        step(0, 0, 0, 4'b0010, "R9 entry");
        step(0, 0, 1, 4'b0100, "R9 alarm commits");
        step(0, 0, 0, 4'b0000, "R9 idle");
        step(0, 0, 1, 4'b0001, "R9 view");
        step(1, 0, 1, 4'b0010, "R9 adjust during view");
        step(0, 0, 1, 4'b0010, "R9 held alarm in entry");
        step(0, 0, 0, 4'b0010, "R9 entry");
        step(0, 1, 0, 4'b1000, "R10 single strobe");
        step(0, 0, 0, 4'b0000, "R10 idle");

        // R1: clear aborts entry
        step(1, 0, 0, 4'b0010, "R1 enter before clear");
        @(negedge clk);
        adj_btn = 1'b0;
        clr = 1'b1;
        #1;
        direct_check(4'b0000, "R1 clear aborts entry");
        @(negedge clk);
        clr = 1'b0;
        step(0, 0, 0, 4'b0000, "R1 idle after clear");

        @(posedge clk);
        @(posedge clk);
        #6;
        report();
    end

endmodule